// File: doc/BRIEF.md
# Two-Channel Dead Time Monitor

The block watches two PWM signals that are already synchronized to the local clock and measures the two directional gaps between them, in clock cycles. Gap A opens when channel 1 leaves its active level and closes when channel 2 next becomes active. Gap B opens when channel 2 leaves its active level and closes when channel 1 next becomes active. Each channel has its own polarity setting, so active-low drive stages can be monitored without external inversion.

Completed gaps are folded into a running minimum and maximum once per channel 1 period, at the point where channel 1 next turns active. An external strobe marks the end of each observation window. At the strobe the running extrema are copied to the outputs and then restarted from their defaults: zero for a maximum and the all-ones count for a minimum. A separate sticky flag reports whether both channels were active at the same time during the current window. The monitoring logic can use this flag to detect shoot-through.

Top module: `dead_time_monitor`

## Requirements
- R1: After a synchronous reset, both minimum outputs equal the saturation count (all ones, 2**CNT_W-1), both maximum outputs are 0, and the overlap flag is 0.
- R2: Gap A equals the number of clock samples from the first sample where channel 1 is inactive after being active, to the first sample where channel 2 is active after being inactive. Simultaneous edges give 0.
- R3: Gap B is measured the same way, from channel 2 going inactive to channel 1 going active. Simultaneous edges give 0.
- R4: Over a window, each minimum output shows the smallest gap committed in that window and each maximum output shows the largest.
- R5: A gap is committed only on the first channel 1 period end (channel 1 turning active) after it closes. A gap whose commit falls after a strobe counts in the later window, even if it opened before that strobe.
- R6: The four extrema outputs change only in the cycle after a strobe. A window with no commit publishes the defaults (max 0, min all ones).
- R7: A polarity input of 1 makes its channel active-low, so a low level is active and all edges are taken on the inverted signal. A polarity input of 0 makes the channel active-high.
- R8: A gap whose closing edge has not arrived stops counting at the all-ones count and is recorded with that value.
- R9: When the overlap check is enabled and both channels are active in one sample, the overlap flag is 1 from the following cycle. It stays 1 until a strobe. The strobe cycle's own sample then sets its new value.
- R10: When the overlap check enable is 0, simultaneous activity does not set the overlap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch1_in | input | 1 | Channel 1 PWM, synchronized |
| ch2_in | input | 1 | Channel 2 PWM, synchronized |
| ch1_act_low | input | 1 | 1: channel 1 active-low |
| ch2_act_low | input | 1 | 1: channel 2 active-low |
| overlap_chk_en | input | 1 | Enables the overlap flag |
| win_strobe | input | 1 | One-cycle end-of-window pulse |
| gap_a_min | output | CNT_W | Smallest gap A of the last window |
| gap_a_max | output | CNT_W | Largest gap A of the last window |
| gap_b_min | output | CNT_W | Smallest gap B of the last window |
| gap_b_max | output | CNT_W | Largest gap B of the last window |
| overlap_flag | output | 1 | Sticky overlap indication for the current window |

## Verification
Several properties are checked on every cycle. The extrema outputs hold still outside strobe cycles, and the reset values appear after reset. A running-extremum update never leaves a committed sample outside the min/max pair. A gap that hits saturation is recorded at the all-ones count. The overlap flag is sticky between strobes and rises only while the check is enabled. The exact gap lengths need the bench's scenarios to show them, and so do simultaneous edges giving zero, the deferred commit at channel 1's period end, gaps that straddle a strobe, inverted polarity, and default publication for empty windows.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/dtm_edge_detect.sv
module dtm_edge_detect
  import dtm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     raw_in,
  input  logic     act_low,
  output edge_ev_t ev
);
  logic lvl;
  logic prev_q;
  logic primed_q;

  assign lvl = raw_in ^ act_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    ev.level = lvl;
    ev.rise  = primed_q & lvl & ~prev_q;
    ev.fall  = primed_q & ~lvl & prev_q;
  end
endmodule

// File: rtl/dtm_gap_timer.sv
module dtm_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_ev,
  input  logic             close_ev,
  input  logic             consume,
  output logic [CNT_W-1:0] held_val,
  output logic             held_vld
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cap;
  logic [CNT_W-1:0] cap_val;

  always_comb begin
    cap     = 1'b0;
    cap_val = cnt_q;
    if (open_ev && close_ev) begin
      cap     = 1'b1;
      cap_val = '0;
    end else if (!open_ev && run_q && (close_ev || cnt_q == SAT)) begin
      cap     = 1'b1;
      cap_val = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      held_val <= '0;
      held_vld <= 1'b0;
    end else begin
      if (open_ev && !close_ev) begin
        run_q <= 1'b1;
        cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (cap) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
      end

      if (cap) begin
        held_val <= cap_val;
        held_vld <= 1'b1;
      end else if (consume) begin
        held_vld <= 1'b0;
      end
    end
  end

  // R8: an interval left open until the limit is recorded at the limit
  assert_saturate_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q == SAT && !close_ev && !open_ev) |=> (held_vld && held_val == SAT && !run_q));
endmodule

// File: rtl/dtm_extrema.sv
module dtm_extrema #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [CNT_W-1:0] smp_val,
  input  logic             win_strobe,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);
  localparam logic [CNT_W-1:0] MIN_DEF = '1;
  localparam logic [CNT_W-1:0] MAX_DEF = '0;

  logic [CNT_W-1:0] run_min_q, run_max_q;
  logic [CNT_W-1:0] nxt_min, nxt_max;

  always_comb begin
    nxt_min = run_min_q;
    nxt_max = run_max_q;
    if (smp_vld) begin
      if (smp_val < run_min_q) nxt_min = smp_val;
      if (smp_val > run_max_q) nxt_max = smp_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_min_q <= MIN_DEF;
      run_max_q <= MAX_DEF;
      min_o     <= MIN_DEF;
      max_o     <= MAX_DEF;
    end else if (win_strobe) begin
      min_o     <= nxt_min;
      max_o     <= nxt_max;
      run_min_q <= MIN_DEF;
      run_max_q <= MAX_DEF;
    end else begin
      run_min_q <= nxt_min;
      run_max_q <= nxt_max;
    end
  end

  // R6: published extrema only move after a strobe
  assert_hold_between_strobes_R6: assert property (@(posedge clk) disable iff (rst)
    !win_strobe |=> ($stable(min_o) && $stable(max_o)));

  // R1: defaults right after reset
  assert_reset_defaults_R1: assert property (@(posedge clk)
    $past(rst) |-> (min_o == MIN_DEF && max_o == MAX_DEF));

  // R4: a committed sample lies inside the running min/max afterwards
  assert_sample_bracketed_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !win_strobe) |=> (run_min_q <= $past(smp_val) && run_max_q >= $past(smp_val)));
endmodule

// File: rtl/dead_time_monitor.sv
module dead_time_monitor
  import dtm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ch1_in,
  input  logic             ch2_in,
  input  logic             ch1_act_low,
  input  logic             ch2_act_low,
  input  logic             overlap_chk_en,
  input  logic             win_strobe,
  output logic [CNT_W-1:0] gap_a_min,
  output logic [CNT_W-1:0] gap_a_max,
  output logic [CNT_W-1:0] gap_b_min,
  output logic [CNT_W-1:0] gap_b_max,
  output logic             overlap_flag
);
  logic [NUM_CH-1:0]  raw;
  logic [NUM_CH-1:0]  pol;
  edge_ev_t           ev [NUM_CH];
  logic [CNT_W-1:0]   gap_val [NUM_CH];
  logic [NUM_CH-1:0]  gap_vld;
  logic [CNT_W-1:0]   ext_min [NUM_CH];
  logic [CNT_W-1:0]   ext_max [NUM_CH];
  logic               period_end_q;
  logic               both_active;

  assign raw = {ch2_in, ch1_in};
  assign pol = {ch2_act_low, ch1_act_low};

  // Index 0 = gap A (ch1 falls -> ch2 rises), index 1 = gap B (ch2 falls -> ch1 rises)
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dtm_edge_detect u_edge (
      .clk     (clk),
      .rst     (rst),
      .raw_in  (raw[g]),
      .act_low (pol[g]),
      .ev      (ev[g])
    );

    dtm_gap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .open_ev  (ev[g].fall),
      .close_ev (ev[NUM_CH-1-g].rise),
      .consume  (period_end_q),
      .held_val (gap_val[g]),
      .held_vld (gap_vld[g])
    );

    dtm_extrema #(.CNT_W(CNT_W)) u_ext (
      .clk        (clk),
      .rst        (rst),
      .smp_vld    (period_end_q & gap_vld[g]),
      .smp_val    (gap_val[g]),
      .win_strobe (win_strobe),
      .min_o      (ext_min[g]),
      .max_o      (ext_max[g])
    );
  end

  assign gap_a_min = ext_min[0];
  assign gap_a_max = ext_max[0];
  assign gap_b_min = ext_min[1];
  assign gap_b_max = ext_max[1];

  assign both_active = overlap_chk_en & ev[0].level & ev[1].level;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_end_q <= 1'b0;
      overlap_flag <= 1'b0;
    end else begin
      period_end_q <= ev[0].rise;
      if (win_strobe) overlap_flag <= both_active;
      else            overlap_flag <= overlap_flag | both_active;
    end
  end

  // R9: the flag stays up until a strobe
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (overlap_flag && !win_strobe) |=> overlap_flag);

  // R10: the flag can only rise while the check is enabled
  assert_flag_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(overlap_flag) |-> $past(overlap_chk_en));
endmodule

// File: tb/test_dead_time_monitor.sv
module test_dead_time_monitor;
  localparam int W    = 8;
  localparam int SATV = 255;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic s1 = 1'b0, s2 = 1'b0, p1 = 1'b0, p2 = 1'b0, en = 1'b0, stb = 1'b0;
  logic [W-1:0] amin, amax, bmin, bmax;
  logic ov;

  dead_time_monitor #(.CNT_W(W)) i_dead_time_monitor (
    .clk(clk), .rst(rst), .ch1_in(s1), .ch2_in(s2),
    .ch1_act_low(p1), .ch2_act_low(p2), .overlap_chk_en(en), .win_strobe(stb),
    .gap_a_min(amin), .gap_a_max(amax), .gap_b_min(bmin), .gap_b_max(bmax),
    .overlap_flag(ov)
  );

  typedef struct {
    int amin; int amax; int bmin; int bmax; string req;
  } exp_t;
  exp_t sbq[$];

  int vectors = 0;
  int miss = 0;

  task automatic check(input int act, input int exp, input string req, input string what);
    vectors++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive active levels; polarity applied here (R7)
  task automatic step(input bit a1, input bit a2, input int n);
    for (int i = 0; i < n; i++) begin
      s1 = a1 ^ p1;
      s2 = a2 ^ p2;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic period(input int h1, input int ga, input int h2, input int gb);
    step(1, 0, h1);
    step(0, 0, ga);
    step(0, 1, h2);
    step(0, 0, gb);
  endtask

  task automatic strobe_expect(input int a0, input int a1, input int b0, input int b1, input string req);
    exp_t e;
    e.amin = a0; e.amax = a1; e.bmin = b0; e.bmax = b1; e.req = req;
    sbq.push_back(e);
    stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic do_reset();
    s1 = p1; s2 = p2;
    stb = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: pops an expectation for every strobe and compares after the edge
  always @(posedge clk) begin
    if (stb && !rst) begin
      @(negedge clk);
      vectors++;
      if (sbq.size() == 0) begin
        miss++;
        $display("FAIL %s: strobe with empty scoreboard, actual %0d expected none", "R6", amin);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (amin != e.amin || amax != e.amax || bmin != e.bmin || bmax != e.bmax) begin
          miss++;
          $display("FAIL %s: actual A %0d/%0d B %0d/%0d expected A %0d/%0d B %0d/%0d",
                   e.req, amin, amax, bmin, bmax, e.amin, e.amax, e.bmin, e.bmax);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    // R1 reset state
    p1 = 0; p2 = 0; en = 1;
    do_reset();
    check(amin, SATV, "R1", "gap_a_min");
    check(amax, 0,    "R1", "gap_a_max");
    check(bmin, SATV, "R1", "gap_b_min");
    check(bmax, 0,    "R1", "gap_b_max");
    check(ov, 0,      "R1", "overlap_flag");

    // R2 R3 R4: three periods, last one closed by a channel 1 rise
    step(0, 0, 3);
    period(5, 3, 5, 4);
    period(5, 7, 5, 2);
    period(5, 5, 5, 6);
    step(1, 0, 3);
    strobe_expect(3, 7, 2, 6, "R2 R3 R4");
    check(ov, 0, "R9", "no overlap seen");

    // R6: window without a channel 1 period end publishes defaults
    step(1, 0, 10);
    strobe_expect(SATV, 0, SATV, 0, "R6");

    // R5: gaps closed but not committed before the strobe, then committed later
    do_reset();
    step(0, 0, 2);
    step(1, 0, 4);
    step(0, 0, 3);
    step(0, 1, 4);
    step(0, 0, 2);
    strobe_expect(SATV, 0, SATV, 0, "R5");
    step(1, 0, 3);
    strobe_expect(3, 3, 3, 3, "R5");

    // R7: both channels active-low
    p1 = 1; p2 = 1;
    do_reset();
    step(0, 0, 2);
    period(4, 6, 4, 9);
    step(1, 0, 2);
    strobe_expect(6, 6, 9, 9, "R7");

    // R8: missing closing edge saturates gap A
    p1 = 0; p2 = 0;
    do_reset();
    step(0, 0, 2);
    step(1, 0, 3);
    step(0, 0, 300);
    step(1, 0, 2);
    strobe_expect(SATV, SATV, SATV, 0, "R8");

    // R2 R3: simultaneous edges give zero
    do_reset();
    step(0, 0, 2);
    step(1, 0, 4);
    step(0, 1, 4);
    step(1, 0, 4);
    strobe_expect(0, 0, 0, 0, "R2 R3");

    // R9 R10: overlap flag
    do_reset();
    en = 1;
    step(0, 0, 2);
    check(ov, 0, "R9", "flag before overlap");
    step(1, 1, 2);
    check(ov, 1, "R9", "flag after overlap");
    step(0, 0, 3);
    check(ov, 1, "R9", "flag sticky");
    strobe_expect(SATV, 0, SATV, 0, "R9");
    check(ov, 0, "R9", "flag cleared by strobe");
    en = 0;
    step(1, 1, 3);
    check(ov, 0, "R10", "flag with check disabled");
    en = 1;
    step(1, 1, 1);
    check(ov, 1, "R10", "flag after re-enable");

    step(0, 0, 4);
    check(sbq.size(), 0, "R6", "scoreboard drained");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule